// File: doc/BRIEF.md
# Power-Down and Over-Temperature Shutdown Controller

This block holds the small control word that decides whether the output stage of a multi-channel converter is live. A host writes the word through a simple register write port. One bit forces a global power-down. A second bit arms an automatic shutdown that reacts to a digital over-temperature flag from an on-die comparator. The block drives one global output-disable line. While that line is high, every channel output is parked at signal ground. The data registers elsewhere in the chip are never touched, so clearing the disable returns every channel to its previous level.

The thermal shutdown latches. Once the synchronised over-temperature flag is seen while armed, the block trips: it raises a read-only status bit and holds the output disabled. This continues after the die cools, and only ends when the host disarms the shutdown by clearing the enable bit. The over-temperature input is asynchronous and passes through a parameterised synchroniser before it is used. Every output is taken from a register and updates on the same clock edge as the state it reflects.

Top module: `pwr_therm_ctrl`

## Requirements
- R1: A write with bit 0 (power-down) set makes `out_disable` high and `status[0]` read 1 from the clock edge that takes the write.
- R2: Whenever bit 0 reads 0 and bit 4 reads 0, `out_disable` is low; a write clearing bit 0 with no trip active releases the disable at that edge.
- R3: Bit 1 (thermal enable) is written by the host and read back in `status[1]` from the edge that takes the write.
- R4: With bit 1 set, a high `over_temp` present before edge k sets `status[4]` and `out_disable` at edge k+SYNC_STAGES (edge k+2 by default).
- R5: While bit 1 is 0 and not being written to 1, `over_temp` has no effect: `status[4]` stays 0 and `out_disable` follows bit 0 alone.
- R6: Once `status[4]` is 1 it stays 1, and `out_disable` stays high, after `over_temp` falls and across writes to bit 0, for as long as bit 1 stays set.
- R7: A write that clears bit 1 clears `status[4]` at the same edge, even while the synchronised flag is still high; `status[4]` never reads 1 with `status[1]` at 0.
- R8: Bit 4 is read-only: writing it has no effect. Bits 2, 3 and 5 and up always read 0.
- R9: After the synchronous reset the status word reads 0 and `out_disable` is low.
- R10: A write that sets bit 1 while the synchronised flag is already high trips at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the control word |
| wr_data | input | CTRL_W | Write data: bit 0 power-down, bit 1 thermal enable, other bits ignored |
| over_temp | input | 1 | Asynchronous die over-temperature flag |
| out_disable | output | 1 | Global output disable: every channel switched to signal ground |
| status | output | CTRL_W | Read value: bit 0 power-down, bit 1 thermal enable, bit 4 thermal trip, rest 0 |

## Verification
Two functions can land on the same edge: a host write that changes the thermal enable, and the synchronised over-temperature flag that would set or hold the trip. The bench provokes this on purpose. It holds `over_temp` high long enough for the flag to reach the trip logic, then issues a write that clears bit 1; clearing must win, leaving the trip bit and the disable low. It then writes bit 1 back to 1 under the same hot flag, and the trip must appear at that same edge. Random writes mixed with long and short over-temperature runs repeat these collisions, and a bench model of the rules judges every cycle.

// File: rtl/pwr_therm_pkg.sv
package pwr_therm_pkg;
  // Bit positions the host software decodes in the control/status word.
  localparam int unsigned PD_BIT   = 0;
  localparam int unsigned TE_BIT   = 1;
  localparam int unsigned TRIP_BIT = 4;
  localparam int unsigned MIN_W    = TRIP_BIT + 1;
endpackage

// File: rtl/pwr_therm_sync.sv
module pwr_therm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwr_therm_regs.sv
module pwr_therm_regs #(
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic              pd_nxt,
  output logic              te_nxt,
  output logic              pd_q,
  output logic              te_q
);
  import pwr_therm_pkg::*;

  // Value each bit takes at the coming edge, shared with the trip logic.
  always_comb begin
    pd_nxt = pd_q;
    te_nxt = te_q;
    if (wr_en) begin
      pd_nxt = wr_data[PD_BIT];
      te_nxt = wr_data[TE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_q <= 1'b0;
      te_q <= 1'b0;
    end else begin
      pd_q <= pd_nxt;
      te_q <= te_nxt;
    end
  end
endmodule

// File: rtl/pwr_therm_trip.sv
module pwr_therm_trip (
  input  logic clk,
  input  logic rst,
  input  logic te_nxt,
  input  logic hot_s,
  output logic trip_nxt,
  output logic trip_q
);
  // Sticky latch: set by the synced flag while armed, cleared only by disarm.
  always_comb trip_nxt = te_nxt & (trip_q | hot_s);

  always_ff @(posedge clk) begin
    if (rst) trip_q <= 1'b0;
    else     trip_q <= trip_nxt;
  end
endmodule

// File: rtl/pwr_therm_ctrl.sv
module pwr_therm_ctrl #(
  parameter int unsigned CTRL_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              over_temp,
  output logic              out_disable,
  output logic [CTRL_W-1:0] status
);
  import pwr_therm_pkg::*;

  localparam logic [CTRL_W-1:0] LIVE_MASK =
    (CTRL_W'(1) << PD_BIT) | (CTRL_W'(1) << TE_BIT) | (CTRL_W'(1) << TRIP_BIT);
  localparam logic [CTRL_W-1:0] SPARE_MASK = ~LIVE_MASK;

  logic hot_s;
  logic pd_nxt, te_nxt, pd_q, te_q;
  logic trip_nxt, trip_q;
  logic [CTRL_W-1:0] status_nxt;

  pwr_therm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(over_temp), .q(hot_s)
  );

  pwr_therm_regs #(.CTRL_W(CTRL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .pd_nxt(pd_nxt), .te_nxt(te_nxt), .pd_q(pd_q), .te_q(te_q)
  );

  pwr_therm_trip u_trip (
    .clk(clk), .rst(rst), .te_nxt(te_nxt), .hot_s(hot_s),
    .trip_nxt(trip_nxt), .trip_q(trip_q)
  );

  always_comb begin
    status_nxt           = '0;
    status_nxt[PD_BIT]   = pd_nxt;
    status_nxt[TE_BIT]   = te_nxt;
    status_nxt[TRIP_BIT] = trip_nxt;
  end

  // Outputs registered from the next-state values so they move with the state.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_disable <= 1'b0;
      status      <= '0;
    end else begin
      out_disable <= pd_nxt | trip_nxt;
      status      <= status_nxt;
    end
  end

  AST_PD_WRITE_DISABLES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[PD_BIT]) |=> (out_disable && status[PD_BIT])); // R1
  AST_IDLE_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (!status[PD_BIT] && !status[TRIP_BIT]) |-> !out_disable); // R2
  AST_TRIP_DISABLES: assert property (@(posedge clk) disable iff (rst)
    status[TRIP_BIT] |-> out_disable); // R4
  AST_COLD_WHEN_DISARMED: assert property (@(posedge clk) disable iff (rst)
    (!status[TE_BIT] && !(wr_en && wr_data[TE_BIT])) |=> !status[TRIP_BIT]); // R5
  AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (status[TRIP_BIT] && !(wr_en && !wr_data[TE_BIT])) |=> status[TRIP_BIT]); // R6
  AST_TRIP_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    status[TRIP_BIT] |-> status[TE_BIT]); // R7
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (status & SPARE_MASK) == '0); // R8
  AST_ARM_WRITE_READS_BACK: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (status[TE_BIT] == $past(wr_data[TE_BIT]))); // R3
endmodule

// File: tb/pwr_therm_ctrl_tb_top.sv
module pwr_therm_ctrl_tb_top;
  localparam int W = 8;
  localparam int NSYNC = 2;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic over_temp = 1'b0;
  logic out_disable;
  logic [W-1:0] status;

  int n_checks = 0;
  int n_fails = 0;
  bit finished = 1'b0;

  // Bench model of the rules
  logic m_pd = 1'b0, m_te = 1'b0, m_trip = 1'b0;
  logic [NSYNC-1:0] m_pipe = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_therm_ctrl #(.CTRL_W(W), .SYNC_STAGES(NSYNC)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .over_temp(over_temp), .out_disable(out_disable), .status(status)
  );

  function automatic logic [W-1:0] exp_status();
    logic [W-1:0] s = '0;
    s[0] = m_pd;
    s[1] = m_te;
    s[4] = m_trip;
    return s;
  endfunction

  function automatic logic exp_disable();
    return m_pd | m_trip;
  endfunction

  task automatic chk(input string tag);
    n_checks++;
    if (status !== exp_status() || out_disable !== exp_disable()) begin
      n_fails++;
      $display("FAIL %s: status=%h disable=%b expected status=%h disable=%b",
               tag, status, out_disable, exp_status(), exp_disable());
    end
  endtask

  // Called at a falling edge: drive inputs, advance model, wait one cycle.
  task automatic cyc(input logic w, input logic [W-1:0] d, input logic hot);
    logic te_eff;
    wr_en = w;
    wr_data = d;
    over_temp = hot;
    te_eff = w ? d[1] : m_te;
    m_trip = te_eff & (m_trip | m_pipe[NSYNC-1]);
    m_te = te_eff;
    if (w) m_pd = d[0];
    m_pipe = {m_pipe[NSYNC-2:0], hot};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1357));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R9 reset state");

    cyc(1, 8'h01, 0); chk("R1 power-down set");
    cyc(1, 8'h00, 0); chk("R2 power-down cleared");
    cyc(1, 8'h02, 0); chk("R3 enable bit read back");

    cyc(0, 8'h00, 1); cyc(0, 8'h00, 1);
    chk("R4 no trip before sync latency");
    cyc(0, 8'h00, 1); chk("R4 trip after sync latency");
    repeat (4) cyc(0, 8'h00, 0);
    chk("R6 trip held after cool-down");
    cyc(1, 8'h03, 0); cyc(1, 8'h02, 0);
    chk("R6 trip held across power-down writes");

    repeat (3) cyc(0, 8'h00, 1);
    cyc(1, 8'h00, 1); chk("R7 disarm clears trip while hot");
    cyc(0, 8'h00, 1); cyc(0, 8'h00, 1);
    chk("R5 hot ignored while disarmed");
    cyc(1, 8'hFC, 1); chk("R8 read-only and spare bits ignored");
    cyc(1, 8'h02, 1); chk("R10 arm while hot trips same edge");
    cyc(1, 8'h00, 0); cyc(0, 8'h00, 0); cyc(0, 8'h00, 0);
    chk("R7 clean after disarm");

    begin
      logic hot = 1'b0;
      for (int i = 0; i < 3000; i++) begin
        logic w;
        logic [W-1:0] d;
        if (($urandom % 8) == 0) hot = ~hot;
        w = (($urandom % 4) == 0);
        d = W'($urandom);
        cyc(w, d, hot);
        chk("RND mixed writes and temperature");
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule